// File: doc/BRIEF.md
# 22 kHz Tone Keyer

This block produces the square-wave carrier used for tone signalling on a satellite feed line and decides, from a squared-up copy of the line signal, whether such a carrier is present. The carrier comes from a programmable divider of the system clock. It reaches the output only when the power path is enabled and no thermal fault is flagged. Under those conditions it is either held on by a force bit or keyed on and off by an external data input, which allows pulse-width keyed messages.

Each keyed burst starts on a fresh carrier phase, so the first half cycle is always complete. The receive side times the interval between rising edges of its input. It calls the carrier present after a run of in-window periods and absent after a silence of about two carrier periods. It reports presence on an active-low output.

With the default divider of 32 and a 1.408 MHz clock, the carrier is 22 kHz at 50% duty. The default detector window of 58 to 78 clocks covers roughly 18 to 24 kHz.

Top module: `tone_keyer`

## Requirements
- R1: During and right after synchronous reset, `tone_out` is 0 and `tone_det_n` is 1.
- R2: While the carrier is gated on, `tone_out` alternates exactly HALF_DIV cycles high and HALF_DIV cycles low (50% duty; 22 kHz at default settings).
- R3: When the gate condition becomes true, `tone_out` goes high in the next cycle and that first high half lasts a full HALF_DIV cycles, whatever phase an earlier burst ended in.
- R4: With `tone_force`=1, `pwr_en`=1 and `over_temp`=0, the carrier runs continuously and changes on `key_in` have no effect on `tone_out`.
- R5: With `tone_force`=0, `key_in`=1 gates the carrier on and `key_in`=0 drives `tone_out` to 0 from the next cycle.
- R6: `pwr_en`=0 or `over_temp`=1 forces `tone_out` to 0 from the next cycle, overriding both `tone_force` and `key_in`.
- R7: A rising edge on `det_in` counts as valid only if its distance to the previous rising edge is between DET_MIN and DET_MAX clocks inclusive (defaults 58 and 78); the first edge after a silence never counts.
- R8: `tone_det_n` goes low once LOCK_PERIODS (default 3) consecutive valid periods have been seen.
- R9: A period outside the window resets the consecutive-period count, so interleaved bad periods prevent the low indication.
- R10: `tone_det_n` returns to 1 once LOSS_CYCLES (default 128) clocks pass with no valid edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_en | input | 1 | Power path enable; 0 blocks the carrier |
| tone_force | input | 1 | 1 holds the carrier on continuously |
| key_in | input | 1 | Keying input used when `tone_force` is 0 |
| over_temp | input | 1 | Thermal fault flag; 1 blocks the carrier |
| det_in | input | 1 | Squared-up line signal for presence detection (asynchronous) |
| tone_out | output | 1 | Gated carrier |
| tone_det_n | output | 1 | 0 while a valid carrier is detected |

## Verification
The embedded properties check the local rules on every cycle. A blocked gate turns the output off one cycle later, a gate that opens yields a high output next cycle, and output edges fall only at a full half-period count. The detector's presence flag rises only on a valid edge after the required run, and it drops only through the silence timeout. The scenarios must show what no single-cycle property can. These are whole waveforms over many periods while the keying input toggles under the force bit, the phase restart after a mid-cycle stop, and the exact window edges at DET_MIN, DET_MAX and one clock beyond each. They also cover the way an off-window period breaks a run, and the timing of the loss of presence after the input falls silent.

// File: rtl/tone_keyer_pkg.sv
// Package: shared helpers for the tone keyer blocks.
// Assumes: period values fit in 32 bits.
package tone_keyer_pkg;

    // True when a measured edge-to-edge period lies inside the accept window.
    function automatic logic period_in_window(input int unsigned period,
                                              input int unsigned lo,
                                              input int unsigned hi);
        return (period >= lo) && (period <= hi);
    endfunction

endpackage

// File: rtl/tone_gate_ctrl.sv
// Module: tone_gate_ctrl
// Combines the enable, fault, force and keying inputs into one carrier gate.
// Assumes: all inputs are synchronous to the system clock.
module tone_gate_ctrl (
    input  logic pwr_en,
    input  logic over_temp,
    input  logic tone_force,
    input  logic key_in,
    output logic gate_on
);

    // Gate: power enable and no fault are mandatory; force or key opens it.
    always_comb begin
        gate_on = pwr_en && !over_temp && (tone_force || key_in);
    end

endmodule

// File: rtl/tone_carrier_gen.sv
// Module: tone_carrier_gen
// Divides the clock into a square carrier of 2*HALF_DIV cycles per period.
// The divider restarts at the beginning of a high half whenever the gate
// opens, so every burst begins with a complete high half.
// Assumes: HALF_DIV >= 2; gate_on is synchronous.
module tone_carrier_gen #(
    parameter int HALF_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    output logic tone_out
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic             run_q;

    // Divider: hold at a fresh high phase while gated off, else count halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
            run_q   <= 1'b0;
        end else if (!gate_on) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
            run_q   <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (!run_q) begin
                cnt_q   <= '0;
                phase_q <= 1'b1;
            end else if (cnt_q == LAST) begin
                cnt_q   <= '0;
                phase_q <= !phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tone_out = run_q && phase_q;

    // R6: a closed gate silences the output on the following cycle.
    assert_blocked_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |=> !tone_out);

    // R3: an opening gate yields a high output on the following cycle.
    assert_fresh_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !$past(gate_on)) |=> tone_out);

    // R2: output edges inside a burst occur only after a full half count.
    assert_half_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && (tone_out != $past(tone_out)))
            |-> ($past(cnt_q) == LAST));

    // R2: the half counter never passes its terminal value.
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/tone_presence_det.sv
// Module: tone_presence_det
// Synchronises a squared-up carrier, measures rising-edge to rising-edge
// periods, and flags presence after a run of in-window periods. Presence
// clears after LOSS_CYCLES clocks without a valid edge.
// Assumes: det_in is asynchronous; DET_MIN <= DET_MAX; LOCK_PERIODS >= 1.
module tone_presence_det
    import tone_keyer_pkg::*;
#(
    parameter int DET_MIN      = 58,
    parameter int DET_MAX      = 78,
    parameter int LOCK_PERIODS = 3,
    parameter int LOSS_CYCLES  = 128,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_in,
    output logic present
);

    localparam int P_W = $clog2(DET_MAX + 2);
    localparam int L_W = $clog2(LOSS_CYCLES + 1);
    localparam int G_W = (LOCK_PERIODS > 1) ? $clog2(LOCK_PERIODS + 1) : 1;
    localparam logic [P_W-1:0] P_SAT = P_W'(DET_MAX + 1);
    localparam logic [L_W-1:0] L_MAX = L_W'(LOSS_CYCLES);
    localparam logic [G_W-1:0] G_MAX = G_W'(LOCK_PERIODS);
    localparam logic [G_W-1:0] G_ARM = G_W'(LOCK_PERIODS - 1);

    logic [SYNC_STAGES:0] chain;
    assign chain[0] = det_in;

    // Synchroniser stages, one flop per generated stage.
    for (genvar g = 1; g <= SYNC_STAGES; g++) begin : gen_sync
        logic stage_q;
        // Stage flop: shift the sampled level one step inward.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= chain[g-1];
        end
        assign chain[g] = stage_q;
    end

    logic             last_q;
    logic             seen_q;
    logic [P_W-1:0]   per_q;
    logic [L_W-1:0]   since_q;
    logic [G_W-1:0]   good_q;
    logic             present_q;
    logic             rise;
    logic             valid_edge;

    assign rise       = chain[SYNC_STAGES] && !last_q;
    assign valid_edge = rise && seen_q &&
                        period_in_window(int'(per_q), DET_MIN, DET_MAX);

    // Period timer: restart on every rising edge, saturate past the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            seen_q <= 1'b0;
            per_q  <= '0;
        end else begin
            last_q <= chain[SYNC_STAGES];
            if (rise) begin
                per_q  <= P_W'(1);
                seen_q <= 1'b1;
            end else if (per_q != P_SAT) begin
                per_q <= per_q + 1'b1;
            end
        end
    end

    // Silence timer: clocks since the last valid edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_q <= '0;
        else if (valid_edge)      since_q <= '0;
        else if (since_q != L_MAX) since_q <= since_q + 1'b1;
    end

    // Run counter and presence flag: lock on a run, clear on silence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q    <= '0;
            present_q <= 1'b0;
        end else if (valid_edge) begin
            if (good_q != G_MAX) good_q <= good_q + 1'b1;
            if (good_q >= G_ARM) present_q <= 1'b1;
        end else if (rise) begin
            good_q <= '0;
        end else if (since_q == L_MAX) begin
            good_q    <= '0;
            present_q <= 1'b0;
        end
    end

    assign present = present_q;

    // R8: presence rises only on a valid edge that completes the run.
    assert_lock_on_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present_q) |-> ($past(valid_edge) && ($past(good_q) >= G_ARM)));

    // R10: presence falls only through the silence timeout.
    assert_drop_on_silence_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present_q) |-> ($past(since_q) == L_MAX));

    // R10: an expired silence timer with no valid edge clears presence.
    assert_timeout_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_q == L_MAX) && !valid_edge) |=> !present_q);

    // R9: a rising edge outside the window empties the run counter.
    assert_bad_edge_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !valid_edge) |=> (good_q == '0));

endmodule

// File: rtl/tone_keyer.sv
// Module: tone_keyer
// Top of the 22 kHz tone keyer: carrier gating, divider and presence detector.
// Assumes: one clock domain except det_in, which is synchronised inside.
module tone_keyer #(
    parameter int HALF_DIV     = 32,
    parameter int DET_MIN      = 58,
    parameter int DET_MAX      = 78,
    parameter int LOCK_PERIODS = 3,
    parameter int LOSS_CYCLES  = 128,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic tone_force,
    input  logic key_in,
    input  logic over_temp,
    input  logic det_in,
    output logic tone_out,
    output logic tone_det_n
);

    logic gate_on;
    logic present;

    tone_gate_ctrl u_gate (
        .pwr_en     (pwr_en),
        .over_temp  (over_temp),
        .tone_force (tone_force),
        .key_in     (key_in),
        .gate_on    (gate_on)
    );

    tone_carrier_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_on  (gate_on),
        .tone_out (tone_out)
    );

    tone_presence_det #(
        .DET_MIN      (DET_MIN),
        .DET_MAX      (DET_MAX),
        .LOCK_PERIODS (LOCK_PERIODS),
        .LOSS_CYCLES  (LOSS_CYCLES),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .det_in  (det_in),
        .present (present)
    );

    assign tone_det_n = !present;

    // R1: nothing is emitted or reported in the first cycle after reset.
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tone_out && tone_det_n));

endmodule

// File: tb/tone_keyer_tb_top.sv
// Bench: scoreboard of scheduled expectations checked at falling edges.
module tone_keyer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 32;
    localparam int DMIN       = 58;
    localparam int DMAX       = 78;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b0;
    logic tone_force = 1'b0;
    logic key_in = 1'b0;
    logic over_temp = 1'b0;
    logic det_in = 1'b0;
    logic tone_out;
    logic tone_det_n;

    int cyc = 0;
    int checks = 0;
    int failures = 0;

    int    q_due[$];
    int    q_kind[$];
    logic  q_val[$];
    string q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tone_keyer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_en     (pwr_en),
        .tone_force (tone_force),
        .key_in     (key_in),
        .over_temp  (over_temp),
        .det_in     (det_in),
        .tone_out   (tone_out),
        .tone_det_n (tone_det_n)
    );

    task automatic push_exp(input int due, input int kind, input logic val, input string req);
        q_due.push_back(due);
        q_kind.push_back(kind);
        q_val.push_back(val);
        q_req.push_back(req);
    endtask

    // Expected carrier burst starting from a gate that opened at cycle base.
    task automatic push_train(input int base, input int len, input string req);
        for (int c = base + 1; c <= base + len; c++)
            push_exp(c, 0, (((c - base - 1) % (2*HALF)) < HALF), req);
    endtask

    task automatic push_zero(input int base, input int len, input string req);
        for (int c = base + 1; c <= base + len; c++)
            push_exp(c, 0, 1'b0, req);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_det(input int period, input int rises);
        for (int r = 0; r < rises; r++) begin
            det_in = 1'b1;
            wait_n(period / 2);
            det_in = 1'b0;
            wait_n(period - period / 2);
        end
    endtask

    task automatic expect_det(input logic val, input string req);
        push_exp(cyc + 1, 1, val, req);
        wait_n(1);
    endtask

    // Monitor: compare every expectation that falls due at this edge.
    always @(negedge clk) begin
        for (int i = q_due.size() - 1; i >= 0; i--) begin
            if (q_due[i] == cyc) begin
                logic act;
                act = (q_kind[i] == 0) ? tone_out : tone_det_n;
                checks++;
                if (act !== q_val[i]) begin
                    failures++;
                    $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", q_req[i],
                             (q_kind[i] == 0) ? "tone_out" : "tone_det_n", act, q_val[i], cyc);
                end
                q_due.delete(i);
                q_kind.delete(i);
                q_val.delete(i);
                q_req.delete(i);
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        // R1: outputs idle in reset and right after it
        wait_n(1);
        push_exp(cyc + 1, 0, 1'b0, "R1");
        push_exp(cyc + 1, 1, 1'b1, "R1");
        wait_n(4);
        rst_n = 1'b1;
        push_exp(cyc + 1, 0, 1'b0, "R1");
        push_exp(cyc + 1, 1, 1'b1, "R1");
        wait_n(3);

        // R2 R4: forced carrier, keying input toggled throughout
        pwr_en = 1'b1; tone_force = 1'b1; base = cyc;
        push_train(base, 256, "R4");
        for (int k = 0; k < 256; k++) begin
            if (k % 7 == 3) key_in = !key_in;
            wait_n(1);
        end

        // R6: power enable low overrides the force bit
        pwr_en = 1'b0; base = cyc;
        push_zero(base, 20, "R6");
        wait_n(20);
        // R3: reopening starts a full high half
        pwr_en = 1'b1; base = cyc;
        push_train(base, 70, "R3");
        wait_n(70);

        // R6: thermal fault overrides the force bit
        over_temp = 1'b1; base = cyc;
        push_zero(base, 20, "R6");
        wait_n(20);
        over_temp = 1'b0; base = cyc;
        push_train(base, 40, "R2");
        wait_n(40);

        // R5: keyed mode, key low silences the carrier
        tone_force = 1'b0; key_in = 1'b0; base = cyc;
        push_zero(base, 10, "R5");
        wait_n(10);
        key_in = 1'b1; base = cyc;
        push_train(base, 40, "R5");
        wait_n(40);
        key_in = 1'b0; base = cyc;
        push_zero(base, 10, "R5");
        wait_n(10);
        // R3: a burst after a mid-period stop restarts at a fresh high half
        key_in = 1'b1; base = cyc;
        push_train(base, 100, "R3");
        wait_n(100);
        key_in = 1'b0;
        wait_n(5);

        // R8: nominal carrier locks after the required run
        expect_det(1'b1, "R8");
        drive_det(2*HALF, 3);
        expect_det(1'b1, "R8");
        drive_det(2*HALF, 2);
        expect_det(1'b0, "R8");
        // R10: short silence keeps presence, long silence clears it
        wait_n(40);
        expect_det(1'b0, "R10");
        wait_n(200);
        expect_det(1'b1, "R10");

        // R9: an off-window period breaks the run
        drive_det(2*HALF, 2);
        drive_det(40, 2);
        drive_det(2*HALF, 2);
        expect_det(1'b1, "R9");
        drive_det(2*HALF, 2);
        expect_det(1'b0, "R9");
        wait_n(300);
        expect_det(1'b1, "R10");

        // R7: window boundaries
        drive_det(DMAX, 5);
        expect_det(1'b0, "R7");
        wait_n(300);
        drive_det(DMIN, 5);
        expect_det(1'b0, "R7");
        wait_n(300);
        drive_det(DMIN - 1, 6);
        expect_det(1'b1, "R7");
        wait_n(300);
        drive_det(DMAX + 1, 6);
        expect_det(1'b1, "R7");
        drive_det(40, 6);
        expect_det(1'b1, "R9");

        wait_n(5);
        if (q_due.size() != 0) begin
            failures += q_due.size();
            $display("FAIL scoreboard actual=%0d expected=0 pending", q_due.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule